// File: doc/BRIEF.md
# Machine-Check Error Logging Bank

This block is one hardware error-reporting bank. It sits next to a cache or bus unit and records the errors that unit detects. Each report is a one-cycle pulse. The pulse carries a 16-bit error code, a correctable/uncorrectable flag, a speculative-access flag, an address-available flag and a physical address. The bank keeps a 64-bit status word and a separate address register. It decides whether an incoming report is written, replaces the current entry, or only marks an overflow.

Two other event sources are folded into the same bank. The first is a hard-failure response on an instruction fetch. The bank logs it and also hands back a completion, so the fetch requester is not left waiting. The second is an error signalled by another agent and only observed here. The bank logs it with its own code, so a handler can tell the cause. Both sources are logged as uncorrectable, with no address.

When a new uncorrectable error is logged, the bank raises a one-cycle machine-check request. Software reads either register through a small select/write port. Software empties the bank by writing zero to the status register.

Top module: `mc_err_bank`

## Requirements
- R1: After reset the status word, the address register, `mc_req` and `fetch_done` are all zero.
- R2: Status layout: bit 63 valid, bit 62 overflow, bit 61 uncorrected, bit 58 address-valid, bits 15:0 error code, all other bits zero. A report accepted into an empty bank sets valid, loads the code and the uncorrected flag, and sets address-valid only when the address was available. It becomes readable on the cycle after the report.
- R3: While an uncorrectable error is held, any further accepted report sets overflow only. Valid, uncorrected, address-valid, code and the address register stay unchanged.
- R4: While a correctable error is held, a further correctable report leaves the entry unchanged and sets overflow.
- R5: While a correctable error is held, an uncorrectable report replaces the entry. Code, uncorrected and address-valid take the new values, and overflow is set.
- R6: A report written into the bank with the address-available flag low leaves address-valid clear and the address register unchanged. With the flag high, the address register loads the reported address.
- R7: A correctable report with the speculative flag set changes neither register. A speculative uncorrectable report is logged normally.
- R8: A fetch hard-failure pulse is logged as an uncorrectable error with code `FETCH_CODE` and no address, and `fetch_done` pulses on the next cycle. If sources pulse in the same cycle, the priority is unit report, then fetch failure, then remote error. Only the winning source is logged.
- R9: A remote-error pulse is logged as an uncorrectable error with code `REMOTE_CODE` and no address.
- R10: Writing zero to the status register (`reg_sel`=0) clears valid, overflow, uncorrected and address-valid. A nonzero write, or any write with `reg_sel`=1, has no effect. A report in the same cycle as the clear is logged into the emptied bank.
- R11: `mc_req` pulses for one cycle, on the cycle after an uncorrectable error is written into a bank that did not already hold one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Unit error report strobe |
| ev_code | input | 16 | Unit error code |
| ev_uncorr | input | 1 | Report is uncorrectable |
| ev_spec | input | 1 | Report came from a speculative access |
| ev_addr_ok | input | 1 | Reported address is valid |
| ev_addr | input | ADDR_W | Reported physical address |
| fetch_fail | input | 1 | Hard-failure response on an instruction fetch |
| remote_err | input | 1 | Error signalled by another agent |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects status, 1 selects address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| mc_req | output | 1 | Machine-check request pulse |
| fetch_done | output | 1 | Completion returned for a failed fetch |

## Verification
Every stored result is a single register stage away from its stimulus. The status and address values, `mc_req` and `fetch_done` all change at the first rising edge after the inputs are presented. `reg_rdata` follows `reg_sel` combinationally from those registers. The bench drives inputs just after a falling edge and steps a behavioural model at the following rising edge. It compares all three outputs at the next falling edge, so each comparison lands exactly one cycle after its stimulus. Collisions, same-cycle clear-and-log, and source priority are all aligned to that one-cycle delay.

// File: rtl/mc_err_bank.sv
`timescale 1ns/1ps
module mc_err_bank #(
  parameter int ADDR_W = 40,
  parameter logic [15:0] FETCH_CODE = 16'h0E0F,
  parameter logic [15:0] REMOTE_CODE = 16'h0E10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [15:0]       ev_code,
  input  logic              ev_uncorr,
  input  logic              ev_spec,
  input  logic              ev_addr_ok,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              fetch_fail,
  input  logic              remote_err,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              mc_req,
  output logic              fetch_done
);
  localparam int PAD_W = 64 - ADDR_W;

  logic val, ovf, unc, av;
  logic [15:0] code;
  logic [ADDR_W-1:0] addr;

  logic e_v, e_unc, e_spec, e_aok;
  logic [15:0] e_code;

  always_comb begin
    e_v = 1'b1; e_unc = 1'b1; e_spec = 1'b0; e_aok = 1'b0; e_code = 16'h0;
    if (ev_valid) begin
      e_unc = ev_uncorr; e_spec = ev_spec; e_aok = ev_addr_ok; e_code = ev_code;
    end else if (fetch_fail) begin
      e_code = FETCH_CODE;
    end else if (remote_err) begin
      e_code = REMOTE_CODE;
    end else begin
      e_v = 1'b0;
    end
  end

  wire clr    = reg_wr & ~reg_sel & (reg_wdata == 64'd0);
  wire accept = e_v & (e_unc | ~e_spec);
  wire h_val  = val & ~clr;
  wire h_ovf  = ovf & ~clr;
  wire h_unc  = unc & ~clr;
  wire h_av   = av  & ~clr;
  wire take   = accept & (~h_val | (e_unc & ~h_unc));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val <= 1'b0; ovf <= 1'b0; unc <= 1'b0; av <= 1'b0;
      code <= '0; addr <= '0; mc_req <= 1'b0; fetch_done <= 1'b0;
    end else begin
      val <= h_val | accept;
      ovf <= h_ovf | (accept & h_val);
      if (take) begin
        unc  <= e_unc;
        code <= e_code;
        av   <= e_aok;
        if (e_aok) addr <= ev_addr;
      end else begin
        unc <= h_unc;
        av  <= h_av;
      end
      mc_req     <= take & e_unc;
      fetch_done <= fetch_fail;
    end
  end

  assign reg_rdata = reg_sel ? {{PAD_W{1'b0}}, addr}
                             : {val, ovf, unc, 2'b00, av, 42'd0, code};

  p_unc_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (val && unc && !clr) |=> (val && unc && code == $past(code) &&
                              av == $past(av) && addr == $past(addr)));

  p_ovf_on_collision_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (val && !clr && ev_valid && (ev_uncorr || !ev_spec)) |=> ovf);

  p_av_needs_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(av) |-> $past(ev_valid && ev_addr_ok));

  p_spec_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_spec && !ev_uncorr && !reg_wr) |=>
      ($stable(val) && $stable(ovf) && $stable(unc) && $stable(av) &&
       $stable(code) && $stable(addr)));

  p_fetch_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_fail |=> fetch_done);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_valid && !fetch_fail && !remote_err) |=> (!val && !ovf && !unc && !av));

  p_mcreq_logged_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mc_req |-> (val && unc));
endmodule

// File: tb/mc_err_bank_tb.sv
`timescale 1ns/1ps
module mc_err_bank_tb_top;
  localparam int CLK_NS = 10;
  localparam logic [15:0] FC = 16'h0E0F;
  localparam logic [15:0] RC = 16'h0E10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_uncorr = 0, ev_spec = 0, ev_addr_ok = 0;
  logic [15:0] ev_code = 0;
  logic [39:0] ev_addr = 0;
  logic fetch_fail = 0, remote_err = 0, reg_wr = 0, reg_sel = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic mc_req, fetch_done;

  always #(CLK_NS/2) clk = ~clk;

  mc_err_bank #(.ADDR_W(40), .FETCH_CODE(FC), .REMOTE_CODE(RC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_uncorr(ev_uncorr), .ev_spec(ev_spec), .ev_addr_ok(ev_addr_ok),
    .ev_addr(ev_addr), .fetch_fail(fetch_fail), .remote_err(remote_err),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mc_req(mc_req), .fetch_done(fetch_done));

  int checks = 0, fails = 0;
  string req = "R1";

  bit m_val, m_ovf, m_unc, m_av, m_mc, m_fd;
  bit [15:0] m_code;
  bit [39:0] m_addr;

  function automatic bit [63:0] exp_rd(bit sel);
    if (sel) return {24'd0, m_addr};
    return {m_val, m_ovf, m_unc, 2'b00, m_av, 42'd0, m_code};
  endfunction

  task automatic chk(string what, bit [63:0] act, bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit [15:0] c, bit u, bit s, bit ao, bit [39:0] a,
                      bit ff, bit rm, bit wr, bit sel, bit [63:0] wd);
    bit is_v, is_u, is_ao, clear, keep;
    bit [15:0] is_c;
    ev_valid = v; ev_code = c; ev_uncorr = u; ev_spec = s; ev_addr_ok = ao;
    ev_addr = a; fetch_fail = ff; remote_err = rm; reg_wr = wr; reg_sel = sel;
    reg_wdata = wd;
    is_v = 1; is_u = 1; is_ao = 0; is_c = 0;
    if (v) begin is_u = u; is_ao = ao; is_c = c; if (!u && s) is_v = 0; end
    else if (ff) is_c = FC;
    else if (rm) is_c = RC;
    else is_v = 0;
    clear = wr && !sel && wd == 0;
    @(posedge clk);
    m_fd = ff;
    m_mc = 0;
    if (clear) begin m_val = 0; m_ovf = 0; m_unc = 0; m_av = 0; end
    if (is_v) begin
      if (!m_val) keep = 0;
      else begin
        m_ovf = 1;
        keep = m_unc || !is_u;
      end
      if (!keep) begin
        if (is_u) m_mc = 1;
        m_val = 1; m_unc = is_u; m_code = is_c; m_av = is_ao;
        if (is_ao) m_addr = a;
      end
    end
    @(negedge clk);
    chk("rdata", reg_rdata, exp_rd(sel));
    chk("mc_req", {63'd0, mc_req}, {63'd0, m_mc});
    chk("fetch_done", {63'd0, fetch_done}, {63'd0, m_fd});
  endtask

  task automatic idle(bit sel); step(0,0,0,0,0,0,0,0,0,sel,0); endtask
  task automatic rep(bit [15:0] c, bit u, bit s, bit ao, bit [39:0] a);
    step(1,c,u,s,ao,a,0,0,0,0,0);
  endtask
  task automatic clr(); step(0,0,0,0,0,0,0,0,1,0,64'd0); endtask

  initial begin
    #(CLK_NS*200000);
    fails++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1"; idle(0); idle(1);
    req = "R2"; rep(16'h1234, 0, 0, 1, 40'hAB_CDEF_0123); idle(1); idle(0);
    req = "R4"; rep(16'h5555, 0, 0, 1, 40'h11_1111_1111); idle(1);
    req = "R5"; rep(16'h7777, 1, 0, 0, 40'h22_2222_2222); idle(1);
    req = "R11"; idle(0);
    req = "R3"; rep(16'h8888, 1, 0, 1, 40'h33_3333_3333); idle(1);
    rep(16'h9999, 0, 0, 1, 40'h44_4444_4444); idle(0);
    req = "R10"; step(0,0,0,0,0,0,0,0,1,0,64'h5); step(0,0,0,0,0,0,0,0,1,1,0);
    clr(); idle(1);
    req = "R6"; rep(16'h0101, 1, 0, 0, 40'h55_5555_5555); idle(1); clr();
    rep(16'h0202, 0, 0, 1, 40'h66_6666_6666); idle(1); clr();
    req = "R7"; rep(16'h0303, 0, 1, 1, 40'h77_7777_7777); idle(1); idle(0);
    rep(16'h0404, 1, 1, 1, 40'h88_8888_8888); idle(1); clr();
    req = "R8"; step(0,0,0,0,0,0,1,0,0,0,0); idle(1); clr();
    step(1,16'h0505,0,0,0,0,1,1,0,0,0); idle(0); clr();
    step(0,0,0,0,0,0,1,1,0,0,0); idle(0); clr();
    req = "R9"; step(0,0,0,0,0,0,0,1,0,0,0); idle(1);
    req = "R10"; step(1,16'h0606,0,0,1,40'h99_9999_9999,0,0,1,0,0); idle(1);
    req = "R11"; step(1,16'h0707,1,0,0,0,0,0,1,0,0); idle(0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule